// File: doc/BRIEF.md
# Age-Ordered Redirect Filter

This block sits at the back of an out-of-order pipeline. It collects the squash requests raised there in a given cycle: branch mispredicts from execution, traps, and squashes caused by an external write to architectural state. It keeps one register with the sequence number of the youngest instruction still valid in the reorder buffer. Each cycle it picks the oldest pending request. It broadcasts that request to the front of the pipeline only if the request is strictly older than the tracked number. Any other request names an instruction that an earlier squash has already removed, so it is dropped.

A broadcast carries the sequence number to squash back to, a cause code, and, for mispredicts, the corrected target and the taken flag. When a broadcast goes out, the tracker drops to the squashing instruction's number. A dispatch raises the tracker to the dispatched number.

Traps are not broadcast at once. A raised trap waits a fixed number of cycles set by the TRAP_LAT parameter. While it waits, further traps are refused. When the wait ends, the trap competes with the other sources like any other request.

Top module: `redir_filter`

## Requirements
- R1: After reset, sq_valid is 0, youngest_seq is 0, trap_busy is 0 and status is 0 (idle).
- R2: A dispatch in a cycle with no accepted redirect sets youngest_seq to disp_seq at that clock edge.
- R3: A request is broadcast only if it is strictly older than youngest_seq. The broadcast appears on sq_valid right after the edge that samples the request (the edge a trap matures for a trap). A request with an equal or younger number causes no broadcast and leaves youngest_seq unchanged.
- R4: When a redirect is accepted, youngest_seq becomes its sequence number and a dispatch in the same cycle is discarded.
- R5: Among requests present in one cycle, the smallest sequence number wins. On equal numbers the priority is trap, then external squash, then mispredict. The sq_cause codes are 1 for a trap, 2 for an external squash and 3 for a mispredict.
- R6: A mispredict broadcast carries mispr_target and mispr_taken. Trap and external broadcasts carry a target of 0 and taken 0.
- R7: A trap sampled at edge E is broadcast after edge E+TRAP_LAT. trap_busy is 1 from edge E until that edge.
- R8: A trap raised while trap_busy is 1 is ignored: it is never broadcast.
- R9: A matured trap that is no longer older than youngest_seq is dropped, and trap_busy clears anyway.
- R10: "Older" means that the SEQ_W-bit difference a-b is negative as a signed number, so ages compare correctly across counter wraparound.
- R11: status is 3 (squash) in the cycle after a broadcast, otherwise 2 (trap wait) while a trap is pending, otherwise 1 (running) once any dispatch has occurred, else 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | An instruction is dispatched this cycle |
| disp_seq | input | SEQ_W | Sequence number of the dispatched instruction |
| mispr_valid | input | 1 | Branch mispredict request |
| mispr_seq | input | SEQ_W | Sequence number of the mispredicted branch |
| mispr_target | input | ADDR_W | Corrected branch target |
| mispr_taken | input | 1 | Corrected taken direction |
| trap_valid | input | 1 | Trap raised this cycle |
| trap_seq | input | SEQ_W | Sequence number of the trapping instruction |
| ext_valid | input | 1 | Squash due to an external state write |
| ext_seq | input | SEQ_W | Sequence number for the external squash |
| sq_valid | output | 1 | Squash broadcast valid (registered) |
| sq_seq | output | SEQ_W | Squash back to this sequence number |
| sq_cause | output | 2 | 1 trap, 2 external, 3 mispredict |
| sq_target | output | ADDR_W | Corrected target (mispredict only) |
| sq_taken | output | 1 | Corrected direction (mispredict only) |
| youngest_seq | output | SEQ_W | Tracked youngest valid sequence number |
| trap_busy | output | 1 | A trap is waiting out its latency |
| status | output | 2 | 0 idle, 1 running, 2 trap wait, 3 squash |

## Verification
The bench targets these corner cases:

- A repeat mispredict at exactly the tracked number must be dropped. A design that compares with less-or-equal would squash twice.
- Equal-number collisions check the tie order. A trap against a mispredict at the same number exposes a design that lets the mispredict target leak onto a trap broadcast.
- A number just past counter wraparound must rank as older. A design using plain unsigned comparison would drop that redirect.
- On the trap path, a second trap raised during the wait must never appear.
- An older mispredict arriving during the wait must cancel the trap at maturity. A design without that check would broadcast a squash for instructions already gone.

// File: rtl/redir_pkg.sv
package redir_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_TRAPW = 2'd2,
    ST_SQSH  = 2'd3
  } status_e;

  localparam logic [1:0] CAUSE_TRAP = 2'd1;
  localparam logic [1:0] CAUSE_EXT  = 2'd2;
  localparam logic [1:0] CAUSE_MISP = 2'd3;

  localparam int N_SRC = 3;

endpackage

// File: rtl/redir_trap_timer.sv
module redir_trap_timer #(
  parameter int SEQ_W    = 8,
  parameter int TRAP_LAT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raise,
  input  logic [SEQ_W-1:0] raise_seq,
  output logic             busy,
  output logic             busy_nxt,
  output logic             fire,
  output logic [SEQ_W-1:0] held_seq
);
  localparam int CNT_W = (TRAP_LAT < 2) ? 1 : $clog2(TRAP_LAT);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(TRAP_LAT - 1);

  logic [CNT_W-1:0] cnt;

  assign fire     = busy && (cnt == '0);
  assign busy_nxt = busy ? !fire : raise;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      held_seq <= '0;
    end else begin
      busy <= busy_nxt;
      if (!busy && raise) begin
        cnt      <= CNT_INIT;
        held_seq <= raise_seq;
      end else if (busy && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_TRAP_HELD: assert property (@(posedge clk) disable iff (rst)
    busy && raise |=> $stable(held_seq)); // R8

  AST_TRAP_WAITS: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) && (TRAP_LAT > 1) |=> busy); // R7

endmodule

// File: rtl/redir_age_arb.sv
module redir_age_arb #(
  parameter int SEQ_W  = 8,
  parameter int ADDR_W = 16,
  parameter int N      = 3
) (
  input  logic [N-1:0]             req_v,
  input  logic [N-1:0][SEQ_W-1:0]  req_seq,
  input  logic [N-1:0][ADDR_W-1:0] req_tgt,
  input  logic [N-1:0]             req_taken,
  input  logic [N-1:0][1:0]        req_cause,
  input  logic [SEQ_W-1:0]         tracker,
  output logic                     accept,
  output logic [SEQ_W-1:0]         win_seq,
  output logic [ADDR_W-1:0]        win_tgt,
  output logic                     win_taken,
  output logic [1:0]               win_cause
);
  function automatic logic is_older(input logic [SEQ_W-1:0] a,
                                    input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  logic have;

  // Lower index wins ties: only a strictly older request replaces the holder.
  always_comb begin
    have      = 1'b0;
    win_seq   = '0;
    win_tgt   = '0;
    win_taken = 1'b0;
    win_cause = '0;
    for (int i = 0; i < N; i++) begin
      if (req_v[i] && (!have || is_older(req_seq[i], win_seq))) begin
        have      = 1'b1;
        win_seq   = req_seq[i];
        win_tgt   = req_tgt[i];
        win_taken = req_taken[i];
        win_cause = req_cause[i];
      end
    end
    accept = have && is_older(win_seq, tracker);
  end

endmodule

// File: rtl/redir_filter.sv
module redir_filter
  import redir_pkg::*;
#(
  parameter int SEQ_W    = 8,
  parameter int ADDR_W   = 16,
  parameter int TRAP_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              disp_valid,
  input  logic [SEQ_W-1:0]  disp_seq,
  input  logic              mispr_valid,
  input  logic [SEQ_W-1:0]  mispr_seq,
  input  logic [ADDR_W-1:0] mispr_target,
  input  logic              mispr_taken,
  input  logic              trap_valid,
  input  logic [SEQ_W-1:0]  trap_seq,
  input  logic              ext_valid,
  input  logic [SEQ_W-1:0]  ext_seq,
  output logic              sq_valid,
  output logic [SEQ_W-1:0]  sq_seq,
  output logic [1:0]        sq_cause,
  output logic [ADDR_W-1:0] sq_target,
  output logic              sq_taken,
  output logic [SEQ_W-1:0]  youngest_seq,
  output logic              trap_busy,
  output logic [1:0]        status
);
  logic             t_busy_nxt, t_fire;
  logic [SEQ_W-1:0] t_seq;
  logic             seen;

  redir_trap_timer #(.SEQ_W(SEQ_W), .TRAP_LAT(TRAP_LAT)) u_timer (
    .clk(clk), .rst(rst), .raise(trap_valid), .raise_seq(trap_seq),
    .busy(trap_busy), .busy_nxt(t_busy_nxt), .fire(t_fire), .held_seq(t_seq)
  );

  logic [N_SRC-1:0]             rv;
  logic [N_SRC-1:0][SEQ_W-1:0]  rseq;
  logic [N_SRC-1:0][ADDR_W-1:0] rtgt;
  logic [N_SRC-1:0]             rtk;
  logic [N_SRC-1:0][1:0]        rcause;

  // Source index order sets tie priority: trap, external, mispredict.
  always_comb begin
    rv     = {mispr_valid, ext_valid, t_fire};
    rseq   = {mispr_seq, ext_seq, t_seq};
    rtgt   = {mispr_target, {ADDR_W{1'b0}}, {ADDR_W{1'b0}}};
    rtk    = {mispr_taken, 1'b0, 1'b0};
    rcause = {CAUSE_MISP, CAUSE_EXT, CAUSE_TRAP};
  end

  logic              acc;
  logic [SEQ_W-1:0]  w_seq;
  logic [ADDR_W-1:0] w_tgt;
  logic              w_tk;
  logic [1:0]        w_cause;

  redir_age_arb #(.SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .N(N_SRC)) u_arb (
    .req_v(rv), .req_seq(rseq), .req_tgt(rtgt), .req_taken(rtk),
    .req_cause(rcause), .tracker(youngest_seq), .accept(acc),
    .win_seq(w_seq), .win_tgt(w_tgt), .win_taken(w_tk), .win_cause(w_cause)
  );

  status_e st_nxt;
  always_comb begin
    if (acc)                     st_nxt = ST_SQSH;
    else if (t_busy_nxt)         st_nxt = ST_TRAPW;
    else if (seen || disp_valid) st_nxt = ST_RUN;
    else                         st_nxt = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_valid     <= 1'b0;
      sq_seq       <= '0;
      sq_cause     <= '0;
      sq_target    <= '0;
      sq_taken     <= 1'b0;
      youngest_seq <= '0;
      seen         <= 1'b0;
      status       <= ST_IDLE;
    end else begin
      sq_valid <= acc;
      if (acc) begin
        sq_seq    <= w_seq;
        sq_cause  <= w_cause;
        sq_target <= w_tgt;
        sq_taken  <= w_tk;
      end
      if (acc)             youngest_seq <= w_seq;
      else if (disp_valid) youngest_seq <= disp_seq;
      seen   <= seen | disp_valid;
      status <= st_nxt;
    end
  end

  AST_BCAST_OLDER: assert property (@(posedge clk) disable iff (rst)
    sq_valid |-> (($signed(sq_seq - $past(youngest_seq))) < 0)); // R3

  AST_TRACKER_DROPS: assert property (@(posedge clk) disable iff (rst)
    sq_valid |-> (youngest_seq == sq_seq)); // R4

  AST_TRAP_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
    sq_valid && sq_cause == CAUSE_TRAP |-> $past(trap_busy)); // R7

  AST_NONMISP_CLEAN: assert property (@(posedge clk) disable iff (rst)
    sq_valid && sq_cause != CAUSE_MISP |-> (sq_target == '0 && !sq_taken)); // R6

  AST_SQ_STATUS: assert property (@(posedge clk) disable iff (rst)
    sq_valid |-> status == ST_SQSH); // R11

endmodule

// File: tb/tb_redir_filter.sv
module tb_redir_filter;
  localparam int SEQ_W = 8, ADDR_W = 16, TRAP_LAT = 4;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic              disp_valid = 0, mispr_valid = 0, mispr_taken = 0;
  logic              trap_valid = 0, ext_valid = 0;
  logic [SEQ_W-1:0]  disp_seq = 0, mispr_seq = 0, trap_seq = 0, ext_seq = 0;
  logic [ADDR_W-1:0] mispr_target = 0;
  logic              sq_valid, sq_taken, trap_busy;
  logic [SEQ_W-1:0]  sq_seq, youngest_seq;
  logic [1:0]        sq_cause, status;
  logic [ADDR_W-1:0] sq_target;

  redir_filter #(.SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .TRAP_LAT(TRAP_LAT)) dut (
    .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_seq(disp_seq),
    .mispr_valid(mispr_valid), .mispr_seq(mispr_seq),
    .mispr_target(mispr_target), .mispr_taken(mispr_taken),
    .trap_valid(trap_valid), .trap_seq(trap_seq),
    .ext_valid(ext_valid), .ext_seq(ext_seq),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .sq_cause(sq_cause),
    .sq_target(sq_target), .sq_taken(sq_taken),
    .youngest_seq(youngest_seq), .trap_busy(trap_busy), .status(status)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    disp_valid = 0; mispr_valid = 0; trap_valid = 0; ext_valid = 0;
    mispr_taken = 0; mispr_target = 0;
  endtask

  task automatic step();
    @(posedge clk); #2;
    clear_in();
  endtask

  typedef struct packed {
    logic dv; logic [7:0] ds;
    logic mv; logic [7:0] ms; logic [15:0] mt; logic mk;
    logic ev; logic [7:0] es;
    logic xv; logic [7:0] xs; logic [1:0] xc; logic [15:0] xt; logic xk;
    logic [7:0] xy; logic [1:0] xst; logic [3:0] rq;
  } vec_t;

  localparam vec_t VT [14] = '{
    '{0,0,   0,0,0,0,           0,0, 0,0,0,0,0,           0,  0,1},  // R1
    '{0,0,   1,3,16'h1111,1,    0,0, 0,0,0,0,0,           0,  0,3},  // R3 idle drop
    '{1,10,  0,0,0,0,           0,0, 0,0,0,0,0,           10, 1,2},  // R2
    '{1,11,  0,0,0,0,           0,0, 0,0,0,0,0,           11, 1,2},  // R2
    '{0,0,   1,5,16'h1234,1,    0,0, 1,5,3,16'h1234,1,    5,  3,6},  // R6
    '{0,0,   1,7,16'h2222,0,    0,0, 0,0,0,0,0,           5,  1,3},  // R3
    '{1,6,   0,0,0,0,           0,0, 0,0,0,0,0,           6,  1,2},  // R2
    '{1,9,   1,4,16'h5555,1,    1,3, 1,3,2,0,0,           3,  3,4},  // R4 R5
    '{0,0,   1,2,16'h6666,1,    1,2, 1,2,2,0,0,           2,  3,5},  // R5 tie
    '{0,0,   1,2,16'h6666,1,    0,0, 0,0,0,0,0,           2,  1,3},  // R3 equal
    '{1,250, 0,0,0,0,           0,0, 0,0,0,0,0,           250,1,2},  // R2
    '{1,5,   0,0,0,0,           0,0, 0,0,0,0,0,           5,  1,10}, // R10
    '{0,0,   1,252,16'h0BEE,0,  0,0, 1,252,3,16'h0BEE,0,  252,3,10}, // R10
    '{0,0,   1,253,16'h0001,1,  0,0, 0,0,0,0,0,           252,1,3}   // R3
  };

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_in();
    repeat (3) @(posedge clk);
    #2;
    chk("R1 sq_valid", sq_valid, 0);
    chk("R1 youngest", youngest_seq, 0);
    chk("R1 trap_busy", trap_busy, 0);
    chk("R1 status", status, 0);
    rst = 0;

    foreach (VT[i]) begin
      disp_valid = VT[i].dv; disp_seq = VT[i].ds;
      mispr_valid = VT[i].mv; mispr_seq = VT[i].ms;
      mispr_target = VT[i].mt; mispr_taken = VT[i].mk;
      ext_valid = VT[i].ev; ext_seq = VT[i].es;
      step();
      chk($sformatf("R%0d row%0d sq_valid", VT[i].rq, i), sq_valid, VT[i].xv);
      if (VT[i].xv) begin
        chk($sformatf("R%0d row%0d sq_seq", VT[i].rq, i), sq_seq, VT[i].xs);
        chk($sformatf("R%0d row%0d cause", VT[i].rq, i), sq_cause, VT[i].xc);
        chk($sformatf("R%0d row%0d target", VT[i].rq, i), sq_target, VT[i].xt);
        chk($sformatf("R%0d row%0d taken", VT[i].rq, i), sq_taken, VT[i].xk);
      end
      chk($sformatf("R%0d row%0d youngest", VT[i].rq, i), youngest_seq, VT[i].xy);
      chk($sformatf("R11 row%0d status", i), status, VT[i].xst);
    end

    // R7 / R8: trap latency, second trap refused
    disp_valid = 1; disp_seq = 20; step();
    trap_valid = 1; trap_seq = 15; step();
    chk("R7 busy after raise", trap_busy, 1);
    chk("R11 trap wait", status, 2);
    for (int k = 1; k <= TRAP_LAT; k++) begin
      if (k == 2) begin trap_valid = 1; trap_seq = 12; end
      step();
      chk($sformatf("R7 sq_valid k=%0d", k), sq_valid, (k == TRAP_LAT) ? 1 : 0);
    end
    chk("R7 trap seq", sq_seq, 15);
    chk("R7 trap cause", sq_cause, 1);
    chk("R4 tracker after trap", youngest_seq, 15);
    chk("R7 busy cleared", trap_busy, 0);
    for (int k = 0; k < TRAP_LAT + 2; k++) begin
      step();
      chk("R8 refused trap absent", sq_valid, 0);
    end
    chk("R8 busy stays clear", trap_busy, 0);

    // R5: trap beats mispredict at equal number
    disp_valid = 1; disp_seq = 30; step();
    trap_valid = 1; trap_seq = 8; step();
    for (int k = 1; k < TRAP_LAT; k++) step();
    mispr_valid = 1; mispr_seq = 8; mispr_target = 16'h7777; mispr_taken = 1;
    step();
    chk("R5 tie valid", sq_valid, 1);
    chk("R5 tie cause trap", sq_cause, 1);
    chk("R6 trap target zero", sq_target, 0);
    chk("R6 trap taken zero", sq_taken, 0);

    // R9: older mispredict during the wait cancels the trap
    disp_valid = 1; disp_seq = 40; step();
    trap_valid = 1; trap_seq = 35; step();
    mispr_valid = 1; mispr_seq = 10; mispr_target = 16'h00AA; step();
    chk("R9 mispredict during wait", sq_valid, 1);
    chk("R9 mispredict seq", sq_seq, 10);
    chk("R9 busy still", trap_busy, 1);
    for (int k = 2; k <= TRAP_LAT; k++) begin
      step();
      chk($sformatf("R9 no trap bcast k=%0d", k), sq_valid, 0);
    end
    chk("R9 busy cleared", trap_busy, 0);
    chk("R9 tracker kept", youngest_seq, 10);
    chk("R11 back to run", status, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule